// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block divides the system clock into time quanta and sequences each CAN bit time as a one-quantum synchronisation segment, a first phase segment and a second phase segment. It puts out a single-cycle quantum tick. It also gives a strobe at the sample point, which is the end of the first phase segment, and a strobe on the last cycle of each bit. A bit-stream engine next to it uses these strobes to sample and to drive the bus. That engine feeds back a hard-sync pulse, which restarts the bit, and a resync pulse with a signed phase error. The resync stretches the first phase segment or trims the second, and the change is limited to the configured jump width.

Two configuration words set the timing. The main word carries the low prescaler bits, the jump width and both segment lengths. The extension word carries the upper prescaler bits. Every field stores its value minus one. A write only lands while both the configuration-change-enable and the initialisation inputs are high.

Top module: `can_bit_timer`

## Requirements
- R1: After reset the main word reads 15'h2301 and the extension word reads 0. This gives a 2-clock quantum, a first phase segment of 4 quanta and a second of 3, so the first sample strobe comes 10 cycles after a hard sync and the first bit end comes 16 cycles after it.
- R2: A write with `cfg_sel_i`=0 loads the main word. Its fields are prescaler low bits [5:0], jump width [7:6], first segment [11:8] and second segment [14:12]. A write with `cfg_sel_i`=1 loads `cfg_wdata_i[3:0]` as prescaler bits [9:6]. Writes take effect only when `ctl_cce_i` and `ctl_init_i` are both 1; otherwise both words are left unchanged.
- R3: One quantum lasts P+1 clock cycles, where P is the 10-bit prescaler value (1 to 1024 cycles). After a hard sync, the first tick comes P+1 cycles later.
- R4: A bit lasts 1 + (TS1+1) + (TS2+1) quanta. `sample_o` pulses on the tick that closes the first phase segment, and `bit_end_o` pulses on the tick that closes the bit. Each bit has exactly one of each, and both only ever fall on ticks.
- R5: A resync with a positive error, applied during the sync or first phase segment, lengthens the first phase segment by min(error, SJW+1) quanta.
- R6: A resync with a negative error, applied during the second phase segment, shortens that segment by min(|error|, SJW+1) quanta. If the new length is already used up, the bit ends on the next tick.
- R7: A resync has no effect if its error is zero, if it is positive during the second phase segment, or if it is negative before that segment. Only the first resync that takes effect in a bit is honoured.
- R8: A hard sync restarts the prescaler and the bit at the sync segment, and it takes priority over a resync in the same cycle. No tick or strobe is produced in the hard-sync cycle, even on a cycle where a quantum boundary was due.
- R9: A resync adjustment applies to the current bit only. The next bit reverts to the configured lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | 0 selects the main word, 1 the extension word |
| cfg_wdata_i | input | 15 | Write data |
| ctl_cce_i | input | 1 | Configuration change enable |
| ctl_init_i | input | 1 | Initialisation mode |
| hsync_i | input | 1 | Hard synchronisation pulse |
| rsync_i | input | 1 | Resynchronisation pulse |
| phase_err_i | input | 5 | Signed phase error, in quanta, for a resync |
| cfg_timing_o | output | 15 | Current main word |
| cfg_ext_o | output | 4 | Current extension word |
| tq_tick_o | output | 1 | Quantum tick |
| sample_o | output | 1 | Sample-point strobe |
| bit_end_o | output | 1 | Last-cycle-of-bit strobe |

## Verification
A hard sync can arrive on the same cycle that the prescaler reaches a quantum boundary. It can also arrive together with a resync. The bench provokes the first case by driving the hard sync exactly on a cycle where a tick is due. It judges the result by the tick being absent in that cycle and by the following sample and bit-end strobes being positioned as if from a fresh start. For the second case, the bench checks that the resync error leaves no trace on the restarted bit.

// File: rtl/cbt_pkg.sv
`timescale 1ns/1ps
package cbt_pkg;
    localparam int BRP_LO_W = 6;
    localparam int BRP_HI_W = 4;
    localparam int SJW_W    = 2;
    localparam int TS1_W    = 4;
    localparam int TS2_W    = 3;
    localparam int DIV_W    = BRP_LO_W + BRP_HI_W;
    localparam int CFG_W    = BRP_LO_W + SJW_W + TS1_W + TS2_W;
    localparam int SJW_LSB  = BRP_LO_W;
    localparam int TS1_LSB  = SJW_LSB + SJW_W;
    localparam int TS2_LSB  = TS1_LSB + TS1_W;
    localparam int L1_W     = TS1_W + 1;
    localparam int L2_W     = TS2_W + 1;
    localparam int Q_W      = L1_W;

    typedef enum logic [1:0] {SEG_SYNC, SEG_PH1, SEG_PH2} seg_e;

    typedef struct packed {
        logic [CFG_W-1:0]    timing;
        logic [BRP_HI_W-1:0] ext;
    } cfg_s;

    typedef struct packed {
        logic [DIV_W-1:0] div_m1;
        logic [SJW_W-1:0] sjw_m1;
        logic [TS1_W-1:0] ts1_m1;
        logic [TS2_W-1:0] ts2_m1;
    } fields_s;
endpackage

// File: rtl/cbt_cfg_regs.sv
`timescale 1ns/1ps
module cbt_cfg_regs
    import cbt_pkg::*;
#(
    parameter logic [CFG_W-1:0]    RST_TIMING = 15'h2301,
    parameter logic [BRP_HI_W-1:0] RST_EXT    = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_i,
    input  logic             sel_i,
    input  logic [CFG_W-1:0] wdata_i,
    input  logic             cce_i,
    input  logic             init_i,
    output cfg_s             cfg_o,
    output fields_s          fld_o
);
    cfg_s cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_i && cce_i && init_i) begin
            if (sel_i) cfg_d.ext = wdata_i[BRP_HI_W-1:0];
            else       cfg_d.timing = wdata_i;
        end
        cfg_o        = cfg_q;
        fld_o.div_m1 = {cfg_q.ext, cfg_q.timing[BRP_LO_W-1:0]};
        fld_o.sjw_m1 = cfg_q.timing[SJW_LSB +: SJW_W];
        fld_o.ts1_m1 = cfg_q.timing[TS1_LSB +: TS1_W];
        fld_o.ts2_m1 = cfg_q.timing[TS2_LSB +: TS2_W];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '{timing: RST_TIMING, ext: RST_EXT};
        else         cfg_q <= cfg_d;
    end
endmodule

// File: rtl/cbt_prescaler.sv
`timescale 1ns/1ps
module cbt_prescaler
    import cbt_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [DIV_W-1:0] div_m1_i,
    input  logic             restart_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        // >= keeps the divider safe when the divisor shrinks mid-quantum
        tick_o = (cnt_q >= div_m1_i) && !restart_i;
        cnt_d  = (restart_i || tick_o) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end
endmodule

// File: rtl/cbt_segment.sv
`timescale 1ns/1ps
module cbt_segment
    import cbt_pkg::*;
#(
    parameter int PE_W = 5
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   tick_i,
    input  logic                   restart_i,
    input  logic                   rsync_i,
    input  logic signed [PE_W-1:0] perr_i,
    input  logic [SJW_W-1:0]       sjw_m1_i,
    input  logic [TS1_W-1:0]       ts1_m1_i,
    input  logic [TS2_W-1:0]       ts2_m1_i,
    output logic                   sample_o,
    output logic                   bit_end_o
);
    typedef struct packed {
        seg_e            seg;
        logic [Q_W-1:0]  qcnt;
        logic [L1_W-1:0] lim1;
        logic [L2_W-1:0] lim2;
        logic            rs_done;
    } seg_state_s;

    seg_state_s st_d, st_q, fresh;
    logic [Q_W-1:0]  q1;
    logic            end1, end2, is_neg;
    logic [PE_W-1:0] mag, sjw_len, clip;

    always_comb begin
        fresh.seg     = SEG_SYNC;
        fresh.qcnt    = '0;
        fresh.lim1    = L1_W'(ts1_m1_i) + 1'b1;
        fresh.lim2    = L2_W'(ts2_m1_i) + 1'b1;
        fresh.rs_done = 1'b0;

        q1   = st_q.qcnt + 1'b1;
        end1 = (st_q.seg == SEG_PH1) && (q1 >= Q_W'(st_q.lim1));
        end2 = (st_q.seg == SEG_PH2) && (q1 >= Q_W'(st_q.lim2));
        sample_o  = tick_i && end1;
        bit_end_o = tick_i && end2;

        is_neg  = perr_i[PE_W-1];
        mag     = is_neg ? PE_W'(-perr_i) : PE_W'(perr_i);
        sjw_len = PE_W'(sjw_m1_i) + 1'b1;
        clip    = (mag > sjw_len) ? sjw_len : mag;

        st_d = st_q;
        if (tick_i) begin
            unique case (st_q.seg)
                SEG_SYNC: begin
                    st_d.seg  = SEG_PH1;
                    st_d.qcnt = '0;
                end
                SEG_PH1: begin
                    if (end1) begin
                        st_d.seg  = SEG_PH2;
                        st_d.qcnt = '0;
                    end else begin
                        st_d.qcnt = q1;
                    end
                end
                SEG_PH2: begin
                    if (end2) st_d = fresh;
                    else      st_d.qcnt = q1;
                end
                default: st_d = fresh;
            endcase
        end

        if (rsync_i && !st_q.rs_done && !bit_end_o && (perr_i != '0)) begin
            if (!is_neg && (st_q.seg != SEG_PH2)) begin
                st_d.lim1    = st_q.lim1 + L1_W'(clip);
                st_d.rs_done = 1'b1;
            end else if (is_neg && (st_q.seg == SEG_PH2)) begin
                st_d.lim2    = (st_q.lim2 > L2_W'(clip)) ? st_q.lim2 - L2_W'(clip)
                                                         : L2_W'(1);
                st_d.rs_done = 1'b1;
            end
        end

        if (restart_i) st_d = fresh;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= fresh;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/can_bit_timer.sv
`timescale 1ns/1ps
module can_bit_timer
    import cbt_pkg::*;
#(
    parameter int                  PE_W       = 5,
    parameter logic [CFG_W-1:0]    RST_TIMING = 15'h2301,
    parameter logic [BRP_HI_W-1:0] RST_EXT    = '0
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   cfg_wr_i,
    input  logic                   cfg_sel_i,
    input  logic [CFG_W-1:0]       cfg_wdata_i,
    input  logic                   ctl_cce_i,
    input  logic                   ctl_init_i,
    input  logic                   hsync_i,
    input  logic                   rsync_i,
    input  logic signed [PE_W-1:0] phase_err_i,
    output logic [CFG_W-1:0]       cfg_timing_o,
    output logic [BRP_HI_W-1:0]    cfg_ext_o,
    output logic                   tq_tick_o,
    output logic                   sample_o,
    output logic                   bit_end_o
);
    cfg_s    cfg;
    fields_s fld;

    cbt_cfg_regs #(.RST_TIMING(RST_TIMING), .RST_EXT(RST_EXT)) regs_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (cfg_wr_i),
        .sel_i   (cfg_sel_i),
        .wdata_i (cfg_wdata_i),
        .cce_i   (ctl_cce_i),
        .init_i  (ctl_init_i),
        .cfg_o   (cfg),
        .fld_o   (fld)
    );

    cbt_prescaler presc_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .div_m1_i  (fld.div_m1),
        .restart_i (hsync_i),
        .tick_o    (tq_tick_o)
    );

    cbt_segment #(.PE_W(PE_W)) seg_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tq_tick_o),
        .restart_i (hsync_i),
        .rsync_i   (rsync_i),
        .perr_i    (phase_err_i),
        .sjw_m1_i  (fld.sjw_m1),
        .ts1_m1_i  (fld.ts1_m1),
        .ts2_m1_i  (fld.ts2_m1),
        .sample_o  (sample_o),
        .bit_end_o (bit_end_o)
    );

    assign cfg_timing_o = cfg.timing;
    assign cfg_ext_o    = cfg.ext;
endmodule

// File: rtl/can_bit_timer_chk.sv
`timescale 1ns/1ps
module can_bit_timer_chk
    import cbt_pkg::*;
(
    input logic                clk_i,
    input logic                rst_ni,
    input logic                cfg_wr_i,
    input logic                ctl_cce_i,
    input logic                ctl_init_i,
    input logic                hsync_i,
    input logic [CFG_W-1:0]    cfg_timing_o,
    input logic [BRP_HI_W-1:0] cfg_ext_o,
    input logic                tq_tick_o,
    input logic                sample_o,
    input logic                bit_end_o
);
    logic [1:0]       smp_q;
    logic [DIV_W-1:0] div_now;

    assign div_now = {cfg_ext_o, cfg_timing_o[BRP_LO_W-1:0]};

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                   smp_q <= 2'd0;
        else if (hsync_i || bit_end_o) smp_q <= 2'd0;
        else if (sample_o && smp_q != 2'd3) smp_q <= smp_q + 2'd1;
    end

    AST_CFG_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(ctl_cce_i && ctl_init_i) |=> $stable(cfg_timing_o) && $stable(cfg_ext_o)); // R2
    AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tq_tick_o && !cfg_wr_i && div_now != '0) |=> !tq_tick_o); // R3
    AST_STROBE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sample_o || bit_end_o) |-> tq_tick_o); // R4
    AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_o |-> !bit_end_o); // R4
    AST_ONE_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bit_end_o |-> smp_q == 2'd1); // R4
    AST_HSYNC_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hsync_i |=> !sample_o && !bit_end_o); // R8
endmodule

bind can_bit_timer can_bit_timer_chk chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_wr_i     (cfg_wr_i),
    .ctl_cce_i    (ctl_cce_i),
    .ctl_init_i   (ctl_init_i),
    .hsync_i      (hsync_i),
    .cfg_timing_o (cfg_timing_o),
    .cfg_ext_o    (cfg_ext_o),
    .tq_tick_o    (tq_tick_o),
    .sample_o     (sample_o),
    .bit_end_o    (bit_end_o)
);

// File: tb/can_bit_timer_tb_top.sv
`timescale 1ns/1ps
module can_bit_timer_tb_top;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr = 1'b0, cfg_sel = 1'b0, cce = 1'b0, init = 1'b0;
    logic [14:0]       wdata = '0;
    logic              hsync = 1'b0, rsync = 1'b0;
    logic signed [4:0] perr = '0;
    logic [14:0]       timing_o;
    logic [3:0]        ext_o;
    logic              tq_tick_o, sample_o, bit_end_o;
    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk; // 250 MHz

    can_bit_timer dut_i (
        .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .cfg_sel_i(cfg_sel),
        .cfg_wdata_i(wdata), .ctl_cce_i(cce), .ctl_init_i(init),
        .hsync_i(hsync), .rsync_i(rsync), .phase_err_i(perr),
        .cfg_timing_o(timing_o), .cfg_ext_o(ext_o),
        .tq_tick_o(tq_tick_o), .sample_o(sample_o), .bit_end_o(bit_end_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [14:0] d, input logic c, input logic i);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; wdata = d; cce = c; init = i;
        @(negedge clk);
        cfg_wr = 1'b0; cce = 1'b0; init = 1'b0;
    endtask

    task automatic set_cfg(input int b, input int s, input int t1, input int t2);
        wr(1'b0, 15'(((t2 & 7) << 12) | ((t1 & 15) << 8) | ((s & 3) << 6) | (b & 63)), 1'b1, 1'b1);
        wr(1'b1, 15'((b >> 6) & 15), 1'b1, 1'b1);
    endtask

    // Hard sync, then count negedges; expected strobe positions in cycles after it.
    task automatic run_case(input string req, input int q, input int l1, input int l2,
                            input int hs_e, input int ra, input int re, input int rb, input int rbe,
                            input int exp_s, input int exp_e1, input int exp_e2, input bit chk_hs);
        int s1 = -1, e1 = -1, e2 = -1, tk = 0, ftk = -1, smp = 0, lim;
        logic hs_tick;
        lim = 3 * (1 + l1 + l2) * q + 8;
        @(negedge clk);
        hsync = 1'b1; rsync = (hs_e != 0); perr = 5'(hs_e);
        #1 hs_tick = tq_tick_o;
        for (int n = 1; n <= lim && e2 < 0; n++) begin
            @(negedge clk);
            hsync = 1'b0;
            rsync = (n == ra) || (n == rb);
            perr  = (n == ra) ? 5'(re) : (n == rb) ? 5'(rbe) : 5'sd0;
            #1;
            if (tq_tick_o) begin
                if (ftk < 0) ftk = n;
                if (e1 < 0) tk++;
            end
            if (sample_o && s1 < 0) s1 = n;
            if (sample_o && e1 < 0) smp++;
            if (bit_end_o) begin
                if (e1 < 0) e1 = n;
                else if (e2 < 0) e2 = n;
            end
        end
        rsync = 1'b0; perr = '0;
        if (chk_hs) chk("R8", "tick in hard-sync cycle", int'(hs_tick), 0);
        chk("R3", "first tick cycle", ftk, q);
        chk("R3", "ticks in first bit", tk, exp_e1 / q);
        chk("R4", "samples in first bit", smp, 1);
        chk(req, "sample cycle", s1, exp_s);
        chk(req, "first bit end cycle", e1, exp_e1);
        chk(req, "second bit end cycle", e2, exp_e2);
    endtask

    initial begin
        #760000;
        n_tests++; n_fail++;
        $display("FAIL watchdog all: actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int bv[4] = '{0, 1, 2, 5};
        int t1v[3] = '{1, 4, 15};
        int t2v[3] = '{0, 3, 7};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset words and default timing
        chk("R1", "reset main word", int'(timing_o), 'h2301);
        chk("R1", "reset extension", int'(ext_o), 0);
        run_case("R1", 2, 4, 3, 0, 0, 0, 0, 0, 10, 16, 32, 0);

        // R2 write protection
        wr(1'b0, 15'h1234, 1'b1, 1'b0);
        chk("R2", "main word, enable only", int'(timing_o), 'h2301);
        wr(1'b0, 15'h1234, 1'b0, 1'b1);
        chk("R2", "main word, init only", int'(timing_o), 'h2301);
        wr(1'b1, 15'h0005, 1'b0, 1'b1);
        chk("R2", "extension, init only", int'(ext_o), 0);
        wr(1'b0, 15'h1234, 1'b1, 1'b1);
        chk("R2", "main word unlocked", int'(timing_o), 'h1234);
        wr(1'b1, 15'h7FF5, 1'b1, 1'b1);
        chk("R2", "extension unlocked", int'(ext_o), 5);
        chk("R2", "main word kept on ext write", int'(timing_o), 'h1234);

        // R4 sweep of prescaler and segment lengths
        foreach (bv[i]) foreach (t1v[j]) foreach (t2v[k]) begin
            int q, l1, l2, nom;
            q = bv[i] + 1; l1 = t1v[j] + 1; l2 = t2v[k] + 1;
            nom = (1 + l1 + l2) * q;
            set_cfg(bv[i], 0, t1v[j], t2v[k]);
            run_case("R4", q, l1, l2, 0, 0, 0, 0, 0, (1 + l1) * q, nom, 2 * nom, 0);
        end

        // R3 wide prescaler using the extension bits
        set_cfg(127, 0, 1, 0);
        run_case("R3", 128, 2, 1, 0, 0, 0, 0, 0, 384, 512, 1024, 0);
        set_cfg(1023, 0, 1, 0);
        run_case("R3", 1024, 2, 1, 0, 0, 0, 0, 0, 3072, 4096, 8192, 0);

        // Resync: q=4, L1=4, L2=3, jump width 2
        set_cfg(3, 1, 3, 2);
        run_case("R5", 4, 4, 3, 0, 6, 5, 0, 0, 28, 40, 72, 0);   // clipped to 2, R9 next bit
        run_case("R5", 4, 4, 3, 0, 6, 1, 0, 0, 24, 36, 68, 0);
        run_case("R6", 4, 4, 3, 0, 22, -7, 0, 0, 20, 24, 56, 0); // R9 next bit nominal
        run_case("R6", 4, 4, 3, 0, 22, -1, 0, 0, 20, 28, 60, 0);
        run_case("R7", 4, 4, 3, 0, 22, 3, 0, 0, 20, 32, 64, 0);  // positive in second segment
        run_case("R7", 4, 4, 3, 0, 6, -3, 0, 0, 20, 32, 64, 0);  // negative in first segment
        run_case("R7", 4, 4, 3, 0, 6, 0, 0, 0, 20, 32, 64, 0);   // zero error
        run_case("R7", 4, 4, 3, 0, 6, 1, 10, 2, 24, 36, 68, 0);  // second resync ignored
        run_case("R8", 4, 4, 3, 3, 0, 0, 0, 0, 20, 32, 64, 0);   // resync with hard sync

        // R8 hard sync on a due quantum boundary (cycle 8 after restart)
        run_case("R8", 4, 4, 3, 0, 0, 0, 0, 0, 20, 32, 64, 0);
        for (int n = 1; n <= 7; n++) @(negedge clk);
        run_case("R8", 4, 4, 3, 0, 0, 0, 0, 0, 20, 32, 64, 1);

        // R6 clamp: jump width 4, L2=5, trim late in the second segment
        set_cfg(3, 3, 3, 4);
        run_case("R6", 4, 4, 5, 0, 30, -7, 0, 0, 20, 32, 72, 0);
        run_case("R5", 4, 4, 5, 0, 6, 7, 0, 0, 36, 56, 96, 0);
        run_case("R9", 4, 4, 5, 0, 0, 0, 0, 0, 20, 40, 80, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule